// File: doc/BRIEF.md
# Work-Frame Command and Status Controller

This block owns the command word of one register frame in a DMA-style traffic generator. Software fills in the frame fields (message address, begin and inclusive end address, stride, substream ID) through a simple register port. It then writes a command code to start a workload. The write is checked in the same clock edge, so the command word can be read straight back and already holds the outcome. The outcome is one of four: running, halted, a runtime error, or a misconfiguration code.

While a workload runs, the frame is frozen and every write is dropped. The datapath is told to start with a one-cycle pulse and the operation code. It ends the work with a done pulse, which may carry a downstream abort and the address that failed. On completion the block asks for an interrupt message whenever the message address is nonzero, whether or not the work failed. It holds that request until a response arrives. A response that reports an abort sets bit 0 of the user control word. A misconfigured frame never asks for a message.

Top module: `work_frame_ctrl`

## Requirements
- R1: After reset the command word reads 0 (no frame), the user control word and the error address read 0, and `irq_req` is low.
- R2: While the command word holds 2, 3 or 4 (running), writes to any field are ignored, and the fields keep their values until `wk_done`.
- R3: Writing 2 (copy), 3 (random fill) or 4 (64-bit sum) with valid fields and a nonzero stride makes the command word read that code on the next read. `wk_start` then pulses for exactly one cycle, with `wk_op` equal to the code.
- R4: Writing 0 or 1 to the command word while idle makes it read 1 (halted) and starts nothing.
- R5: A `wk_done` pulse while running makes the command word read 1 on success or 0xFFFFFFFF (error) when `wk_abort` is high. `irq_req` rises in both cases if the message address is nonzero, and stays low if it is zero.
- R6: A command write that yields misconfigured (0xFFFFFFFE) never raises `irq_req`.
- R7: `irq_req` stays high until `irq_resp_valid`. A response with `irq_resp_abort` high sets bit 0 of the user control word, and a response without it leaves that word unchanged.
- R8: For code 4, a begin address with low three bits not 000, or an inclusive end address with low three bits not 111, gives misconfigured.
- R9: A substream ID that is neither 0xFFFFFFFF nor below 2^20 gives misconfigured for any start code. 0xFFFFF is accepted.
- R10: A start code with valid fields and a zero stride gives error (0xFFFFFFFF), records the begin address as the error address, starts nothing, and raises `irq_req` when the message address is nonzero. A done with abort records `wk_fail_addr` as the error address.
- R11: Any written code other than 0 to 4, including 0xFFFFFFFE and 0xFFFFFFFF themselves, gives misconfigured and starts nothing.
- R12: Field selects on the register port are: 0 command (low 32 bits), 1 user control (low 32 bits), 2 message address, 3 begin, 4 inclusive end, 5 stride, 6 substream ID (low 32 bits), 7 error address (read only; writes ignored). A `wk_done` pulse while not running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Field selected for the write |
| wr_data | input | ADDR_W | Write data |
| rd_sel | input | SEL_W | Field selected for the read |
| rd_data | output | ADDR_W | Combinational read data |
| wk_start | output | 1 | One-cycle start pulse to the datapath |
| wk_op | output | 3 | Operation code for the datapath |
| wk_done | input | 1 | Workload finished pulse |
| wk_abort | input | 1 | Qualifies `wk_done`: downstream abort |
| wk_fail_addr | input | ADDR_W | Failing address with an abort |
| irq_req | output | 1 | Interrupt message request |
| irq_addr | output | ADDR_W | Message address for the request |
| irq_resp_valid | input | 1 | Interrupt message response |
| irq_resp_abort | input | 1 | Response reports an abort |

## Verification
The bench builds the block with its defaults: 64-bit addresses, a 3-bit field select and a 20-bit substream width. With these values the substream bound sits exactly between 0xFFFFF and 0x100000, and the all-ones "none" value is reachable. A full 64-bit error address tests the upper half of the recorded fault address. The scoreboard then walks every terminal state: halted, error from a zero stride, error from an abort, and misconfigured from each invalid code and field. Between those steps it writes to the frame while the workload runs.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int CMD_W = 32;

  localparam logic [CMD_W-1:0] CMD_NOFRAME = 32'd0;
  localparam logic [CMD_W-1:0] CMD_HALT    = 32'd1;
  localparam logic [CMD_W-1:0] CMD_COPY    = 32'd2;
  localparam logic [CMD_W-1:0] CMD_FILL    = 32'd3;
  localparam logic [CMD_W-1:0] CMD_SUM     = 32'd4;
  localparam logic [CMD_W-1:0] CMD_MISCONF = 32'hFFFF_FFFE;
  localparam logic [CMD_W-1:0] CMD_ERROR   = 32'hFFFF_FFFF;

  localparam int SEL_CMD  = 0;
  localparam int SEL_CTRL = 1;
  localparam int SEL_MSI  = 2;
  localparam int SEL_BEG  = 3;
  localparam int SEL_END  = 4;
  localparam int SEL_STR  = 5;
  localparam int SEL_SSID = 6;
  localparam int SEL_ERR  = 7;

  typedef enum logic [1:0] {
    V_HALT    = 2'd0,
    V_START   = 2'd1,
    V_ZSTRIDE = 2'd2,
    V_MISCONF = 2'd3
  } verdict_e;

  function automatic logic is_running(input logic [CMD_W-1:0] c);
    return (c >= CMD_COPY) && (c <= CMD_SUM);
  endfunction
endpackage

// File: rtl/wf_validator.sv
module wf_validator #(
  parameter int ADDR_W = 64,
  parameter int SSID_W = 20
) (
  input  logic [31:0]       code,
  input  logic [31:0]       ssid,
  input  logic [2:0]        beg_lo,
  input  logic [2:0]        fin_lo,
  input  logic [ADDR_W-1:0] stride,
  output wf_pkg::verdict_e  verdict
);
  import wf_pkg::*;

  function automatic logic ssid_ok(input logic [31:0] s);
    return (s == 32'hFFFF_FFFF) || ((s >> SSID_W) == 32'd0);
  endfunction

  function automatic logic sum_aligned(input logic [2:0] b, input logic [2:0] e);
    return (b == 3'b000) && (e == 3'b111);
  endfunction

  logic fields_bad;
  always_comb begin
    fields_bad = !ssid_ok(ssid) || ((code == CMD_SUM) && !sum_aligned(beg_lo, fin_lo));
    if (code == CMD_NOFRAME || code == CMD_HALT)
      verdict = V_HALT;
    else if (!is_running(code) || fields_bad)
      verdict = V_MISCONF;
    else if (stride == '0)
      verdict = V_ZSTRIDE;
    else
      verdict = V_START;
  end
endmodule

// File: rtl/wf_irq_unit.sv
module wf_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic resp_valid,
  input  logic resp_abort,
  output logic irq_req,
  output logic ev_abort
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          req_q <= 1'b0;
    else if (raise)      req_q <= 1'b1;
    else if (resp_valid) req_q <= 1'b0;
  end

  assign irq_req  = req_q;
  assign ev_abort = resp_valid && resp_abort && req_q;

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !resp_valid) |=> req_q);
  assert_resp_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && resp_valid && !raise) |=> !req_q);
endmodule

// File: rtl/work_frame_ctrl.sv
module work_frame_ctrl #(
  parameter int ADDR_W = 64,
  parameter int SSID_W = 20,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_data,
  output logic              wk_start,
  output logic [2:0]        wk_op,
  input  logic              wk_done,
  input  logic              wk_abort,
  input  logic [ADDR_W-1:0] wk_fail_addr,
  output logic              irq_req,
  output logic [ADDR_W-1:0] irq_addr,
  input  logic              irq_resp_valid,
  input  logic              irq_resp_abort
);
  import wf_pkg::*;
  localparam int PAD = ADDR_W - CMD_W;

  logic [CMD_W-1:0]  cmd_q, uctrl_q, ssid_q;
  logic [ADDR_W-1:0] msi_q, beg_q, fin_q, stride_q, err_q;
  logic              start_q;

  // named internal events
  logic     running, idle_wr, cmd_wr;
  logic     ev_start, ev_misconf, ev_zstride, ev_finish, ev_irq_abort, irq_raise;
  verdict_e verdict;

  assign running    = is_running(cmd_q);
  assign idle_wr    = wr_en && !running;
  assign cmd_wr     = idle_wr && (wr_sel == SEL_W'(SEL_CMD));
  assign ev_start   = cmd_wr && (verdict == V_START);
  assign ev_misconf = cmd_wr && (verdict == V_MISCONF);
  assign ev_zstride = cmd_wr && (verdict == V_ZSTRIDE);
  assign ev_finish  = running && wk_done;
  assign irq_raise  = (ev_finish || ev_zstride) && (msi_q != '0);

  wf_validator #(.ADDR_W(ADDR_W), .SSID_W(SSID_W)) u_valid (
    .code    (wr_data[CMD_W-1:0]),
    .ssid    (ssid_q),
    .beg_lo  (beg_q[2:0]),
    .fin_lo  (fin_q[2:0]),
    .stride  (stride_q),
    .verdict (verdict)
  );

  wf_irq_unit u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise      (irq_raise),
    .resp_valid (irq_resp_valid),
    .resp_abort (irq_resp_abort),
    .irq_req    (irq_req),
    .ev_abort   (ev_irq_abort)
  );

  // command word
  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= CMD_NOFRAME;
    else if (ev_finish) cmd_q <= wk_abort ? CMD_ERROR : CMD_HALT;
    else if (cmd_wr) begin
      unique case (verdict)
        V_HALT:    cmd_q <= CMD_HALT;
        V_START:   cmd_q <= wr_data[CMD_W-1:0];
        V_ZSTRIDE: cmd_q <= CMD_ERROR;
        default:   cmd_q <= CMD_MISCONF;
      endcase
    end
  end

  // plain frame fields, writable only while idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msi_q <= '0; beg_q <= '0; fin_q <= '0; stride_q <= '0; ssid_q <= '0;
    end else if (idle_wr) begin
      if (wr_sel == SEL_W'(SEL_MSI))  msi_q    <= wr_data;
      if (wr_sel == SEL_W'(SEL_BEG))  beg_q    <= wr_data;
      if (wr_sel == SEL_W'(SEL_END))  fin_q    <= wr_data;
      if (wr_sel == SEL_W'(SEL_STR))  stride_q <= wr_data;
      if (wr_sel == SEL_W'(SEL_SSID)) ssid_q   <= wr_data[CMD_W-1:0];
    end
  end

  // user control: software value, engine sets bit 0 on message abort
  always_ff @(posedge clk) begin
    if (!rst_n) uctrl_q <= '0;
    else begin
      if (idle_wr && wr_sel == SEL_W'(SEL_CTRL)) uctrl_q <= wr_data[CMD_W-1:0];
      if (ev_irq_abort) uctrl_q[0] <= 1'b1;
    end
  end

  // error address
  always_ff @(posedge clk) begin
    if (!rst_n)                       err_q <= '0;
    else if (ev_finish && wk_abort)   err_q <= wk_fail_addr;
    else if (ev_zstride)              err_q <= beg_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= ev_start;
  end

  assign wk_start = start_q;
  assign wk_op    = cmd_q[2:0];
  assign irq_addr = msi_q;

  always_comb begin
    unique case (int'(rd_sel))
      SEL_CMD:  rd_data = {{PAD{1'b0}}, cmd_q};
      SEL_CTRL: rd_data = {{PAD{1'b0}}, uctrl_q};
      SEL_MSI:  rd_data = msi_q;
      SEL_BEG:  rd_data = beg_q;
      SEL_END:  rd_data = fin_q;
      SEL_STR:  rd_data = stride_q;
      SEL_SSID: rd_data = {{PAD{1'b0}}, ssid_q};
      default:  rd_data = err_q;
    endcase
  end

  assert_busy_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wk_done) |=> (cmd_q == $past(cmd_q)));
  assert_busy_field_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(beg_q) && $stable(stride_q) && $stable(msi_q));
  assert_start_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wk_start |-> running);
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wk_start |=> !wk_start);
  assert_finish_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_finish && msi_q != '0) |=> irq_req);
  assert_misconf_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_misconf && !irq_req) |=> !irq_req);
  assert_abort_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_abort |=> uctrl_q[0]);
  assert_misconf_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_misconf |=> (cmd_q == CMD_MISCONF));
  assert_zstride_nostart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zstride |=> (!wk_start && cmd_q == CMD_ERROR));
endmodule

// File: tb/work_frame_ctrl_bench.sv
`timescale 1ns/1ps
module work_frame_ctrl_bench;
  localparam int AW = 64;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [SW-1:0] wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic [SW-1:0] rd_sel = '0;
  logic [AW-1:0] rd_data;
  logic          wk_start;
  logic [2:0]    wk_op;
  logic          wk_done = 1'b0;
  logic          wk_abort = 1'b0;
  logic [AW-1:0] wk_fail_addr = '0;
  logic          irq_req;
  logic [AW-1:0] irq_addr;
  logic          irq_resp_valid = 1'b0;
  logic          irq_resp_abort = 1'b0;

  always #4 clk = ~clk;

  work_frame_ctrl #(.ADDR_W(AW), .SSID_W(20), .SEL_W(SW)) u_work_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .wk_start(wk_start), .wk_op(wk_op),
    .wk_done(wk_done), .wk_abort(wk_abort), .wk_fail_addr(wk_fail_addr),
    .irq_req(irq_req), .irq_addr(irq_addr),
    .irq_resp_valid(irq_resp_valid), .irq_resp_abort(irq_resp_abort));

  localparam logic [AW-1:0] MISC = 64'hFFFF_FFFE;
  localparam logic [AW-1:0] ERRC = 64'hFFFF_FFFF;
  localparam int K_REG = 0, K_IRQ = 1, K_STARTS = 2, K_OP = 3;

  typedef struct {
    int            kind;
    int            sel;
    logic [AW-1:0] exp;
    string         tag;
  } item_t;

  item_t q[$];
  bit    mon_busy = 1'b0;
  int    nchk = 0, nerr = 0, starts = 0, cycles = 0;
  logic [2:0] last_op = '0;
  bit    done_flag = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (wk_start) begin starts <= starts + 1; last_op <= wk_op; end
  end

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      if (q.size() == 0) #1;
      else begin
        item_t it;
        logic [AW-1:0] act;
        mon_busy = 1'b1;
        it = q.pop_front();
        if (it.kind == K_REG) begin rd_sel = SW'(it.sel); #1; act = rd_data; end
        else begin
          #1;
          if (it.kind == K_IRQ)         act = AW'(irq_req);
          else if (it.kind == K_STARTS) act = AW'(starts);
          else                          act = AW'(last_op);
        end
        nchk++;
        if (act !== it.exp) begin
          nerr++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic expect_item(input int kind, input int sel, input logic [AW-1:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0 || mon_busy) #1;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = SW'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse(input bit abort, input logic [AW-1:0] addr);
    @(negedge clk);
    wk_done = 1'b1; wk_abort = abort; wk_fail_addr = addr;
    @(negedge clk);
    wk_done = 1'b0; wk_abort = 1'b0;
  endtask

  task automatic respond(input bit abort);
    @(negedge clk);
    irq_resp_valid = 1'b1; irq_resp_abort = abort;
    @(negedge clk);
    irq_resp_valid = 1'b0; irq_resp_abort = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    expect_item(K_REG, 0, 64'd0, "R1 cmd after reset");
    expect_item(K_REG, 1, 64'd0, "R1 uctrl after reset");
    expect_item(K_IRQ, 0, 64'd0, "R1 irq after reset");
    drain();
    expect_item(K_REG, 7, 64'd0, "R1 error address after reset");
    drain();

    // frame setup and a copy
    wr(2, 64'h1000); wr(3, 64'h100); wr(4, 64'h1FF); wr(5, 64'd8); wr(6, 64'hFFFF_FFFF);
    expect_item(K_REG, 3, 64'h100, "R12 begin readback");
    drain();
    wr(0, 64'd2);
    expect_item(K_REG, 0, 64'd2, "R3 copy reads back");
    drain();
    tick();
    expect_item(K_STARTS, 0, 64'd1, "R3 one start pulse");
    expect_item(K_OP, 0, 64'd2, "R3 op code");
    drain();
    repeat (3) tick();
    expect_item(K_STARTS, 0, 64'd1, "R3 pulse not repeated");
    drain();

    // writes while running
    wr(0, 64'd1); wr(3, 64'h555);
    expect_item(K_REG, 0, 64'd2, "R2 cmd write ignored while running");
    expect_item(K_REG, 3, 64'h100, "R2 begin write ignored while running");
    drain();

    // success completion with message address set
    done_pulse(1'b0, '0);
    expect_item(K_REG, 0, 64'd1, "R5 halted after done");
    expect_item(K_IRQ, 0, 64'd1, "R5 irq raised on success");
    drain();
    repeat (2) tick();
    expect_item(K_IRQ, 0, 64'd1, "R7 irq held until response");
    drain();
    respond(1'b1);
    expect_item(K_IRQ, 0, 64'd0, "R7 irq cleared by response");
    expect_item(K_REG, 1, 64'd1, "R7 abort sets control bit 0");
    drain();

    // writing 0 means halted
    wr(0, 64'd0);
    expect_item(K_REG, 0, 64'd1, "R4 zero write reads halted");
    drain();

    // sum alignment
    wr(3, 64'h104); wr(0, 64'd4);
    expect_item(K_REG, 0, MISC, "R8 misaligned begin");
    expect_item(K_IRQ, 0, 64'd0, "R6 no irq on misconfig");
    drain();
    wr(3, 64'h100); wr(4, 64'h1FE); wr(0, 64'd4);
    expect_item(K_REG, 0, MISC, "R8 misaligned end");
    drain();
    wr(4, 64'h1FF);

    // substream bound
    wr(6, 64'h10_0000); wr(0, 64'd3);
    expect_item(K_REG, 0, MISC, "R9 substream too wide");
    drain();
    tick();
    expect_item(K_STARTS, 0, 64'd1, "R9 misconfig starts nothing");
    expect_item(K_IRQ, 0, 64'd0, "R6 still no irq");
    drain();
    wr(6, 64'hF_FFFF); wr(0, 64'd3);
    expect_item(K_REG, 0, 64'd3, "R9 max substream accepted");
    drain();
    tick();
    expect_item(K_STARTS, 0, 64'd2, "R3 fill started");
    expect_item(K_OP, 0, 64'd3, "R3 fill op code");
    drain();

    // runtime abort
    done_pulse(1'b1, 64'hDEAD_BEEF_0000_1234);
    expect_item(K_REG, 0, ERRC, "R5 error after abort");
    expect_item(K_REG, 7, 64'hDEAD_BEEF_0000_1234, "R10 fail address recorded");
    expect_item(K_IRQ, 0, 64'd1, "R5 irq raised on error");
    drain();
    respond(1'b0);
    expect_item(K_IRQ, 0, 64'd0, "R7 irq cleared");
    expect_item(K_REG, 1, 64'd1, "R7 clean response leaves control");
    drain();

    // invalid codes
    wr(0, 64'd7);
    expect_item(K_REG, 0, MISC, "R11 code 7 invalid");
    drain();
    wr(0, 64'hFFFF_FFFD);
    expect_item(K_REG, 0, MISC, "R11 code all-ones minus two invalid");
    drain();
    wr(0, ERRC);
    expect_item(K_REG, 0, MISC, "R11 error code written is invalid");
    expect_item(K_IRQ, 0, 64'd0, "R6 no irq after invalid codes");
    drain();

    // zero stride
    wr(5, 64'd0); wr(0, 64'd2);
    expect_item(K_REG, 0, ERRC, "R10 zero stride gives error");
    expect_item(K_REG, 7, 64'h100, "R10 begin recorded");
    expect_item(K_IRQ, 0, 64'd1, "R10 irq on zero stride");
    drain();
    tick();
    expect_item(K_STARTS, 0, 64'd2, "R10 zero stride starts nothing");
    drain();
    respond(1'b0);

    // no message address: no irq
    wr(5, 64'd8); wr(2, 64'd0); wr(0, 64'd2);
    tick();
    expect_item(K_STARTS, 0, 64'd3, "R3 copy started again");
    drain();
    done_pulse(1'b0, '0);
    expect_item(K_REG, 0, 64'd1, "R5 halted");
    expect_item(K_IRQ, 0, 64'd0, "R5 no irq with zero address");
    drain();

    // done while idle, error address write
    done_pulse(1'b1, 64'h42);
    expect_item(K_REG, 0, 64'd1, "R12 stray done ignored");
    expect_item(K_REG, 7, 64'h100, "R12 stray done keeps error address");
    drain();
    wr(7, 64'h77);
    expect_item(K_REG, 7, 64'h100, "R12 error address read only");
    drain();

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!done_flag) begin
      nchk++; nerr++;
      $display("FAIL watchdog R1..all actual=%0d expected<=5000", cycles);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule